// File: doc/BRIEF.md
# Multi-Channel Zero-Data Detector

This block watches the sample streams of twelve output-converter channels and raises flags when the channels it is watching have carried nothing but zero data for a long enough run. Each channel has its own run-length counter. The counter advances on every strobed all-zero sample and clears on any strobed nonzero sample. A channel counts as silent once its counter has seen `ZRUN` zero samples in a row. A 4-bit grouping code splits the channels between two flag outputs. A flag is set only when every powered-up channel assigned to its group is silent.

The first flag output is shared. A select input can route an external overflow indication onto it instead of the zero-detect result, and zero detection is then inactive. Several conditions override the detection result. Both flags are held low while the block is in reset, and also for a blanking window after reset is released. Both flags are driven high while the internal-reset control is low. The grouping code 1111 switches detection off. Channels that are powered down still run their counters, but they are left out of both groups.

Top module: `zrun_flag_top`

## Requirements
- R1: While `rst_n` is low, `flag_a` and `flag_b` are both 0 and every run counter is cleared.
- R2: After `rst_n` rises, both flags stay 0 until `HOLD_SMP` (default 10) `sample_vld` strobes have been counted. They are free to change on the clock edge after the edge that counts the last of those strobes.
- R3: Outside the blanking window, `run_en` = 0 drives both flags to 1 and clears every run counter.
- R4: A channel becomes silent after `ZRUN` consecutive strobed samples equal to zero. A strobed nonzero sample clears its run. Data presented while `sample_vld` is 0 has no effect.
- R5: With `run_en` = 1 and `ovf_sel` = 1, `flag_a` takes the value `ovf_in` had one cycle earlier, and `flag_b` is 0.
- R6: Grouping code 4'b1111 drives both flags to 0.
- R7: Grouping code 4'b0000 places all twelve channels in group A, and group B is empty, so `flag_b` is 0.
- R8: Grouping codes k = 1 to 11 place channels with index >= 12-k in group B and all other channels in group A.
- R9: Code 4'b1100 puts even-index channels in A and odd-index channels in B. Code 4'b1101 puts channels whose index bit 1 is 0 in A and the rest in B. Code 4'b1110 puts every channel in both groups.
- R10: A channel whose `ch_pd` bit is 1 does not affect either flag. A group with no powered-up member gives a flag of 0.
- R11: The flags are registered. A run that completes on the strobe at clock edge e shows on the flags at edge e+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-down reset |
| run_en | input | 1 | Internal-reset control; 0 forces both flags high and clears the run counters |
| mode | input | 4 | Channel grouping code |
| ovf_sel | input | 1 | 1 routes `ovf_in` onto `flag_a` |
| ovf_in | input | 1 | External overflow indication |
| sample_vld | input | 1 | One strobe per sample period, common to all channels |
| ch_pd | input | NCH (12) | Per-channel power-down, 1 = powered down |
| ch_data | input | NCH*DW (288) | Channel samples, channel c at bits [c*DW +: DW] |
| flag_a | output | 1 | Group A zero flag, or the overflow flag |
| flag_b | output | 1 | Group B zero flag |

## Verification
Some properties are checked by assertions on every cycle: the override order of blanking, internal reset, overflow routing and the disabled code; the rule that a strobed nonzero sample clears a channel's silent state; the rule that silence can only begin on a strobed zero sample; and the rule that a group with no powered-up member stays low. Other behaviour can only be shown by the bench's scenarios, run against its own model of the counters: the exact grouping of each code, the masking of powered-down channels inside a mixed group, the exact length of the blanking window, and the single-cycle flag latency.

// File: rtl/zrun_pkg.sv
package zrun_pkg;

  // grouping codes with a fixed meaning; codes 1..11 select a tail split
  localparam logic [3:0] ZR_MODE_ALL  = 4'h0;
  localparam logic [3:0] ZR_MODE_EVEN = 4'hC;
  localparam logic [3:0] ZR_MODE_PAIR = 4'hD;
  localparam logic [3:0] ZR_MODE_BOTH = 4'hE;
  localparam logic [3:0] ZR_MODE_OFF  = 4'hF;

  // which source currently owns the flag outputs
  typedef enum logic [2:0] {
    SRC_BLANK,
    SRC_IRST,
    SRC_OVF,
    SRC_OFF,
    SRC_GRP
  } zr_src_e;

endpackage

// File: rtl/zrun_chan.sv
module zrun_chan #(
  parameter int DW   = 24,
  parameter int ZRUN = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          vld,
  input  logic [DW-1:0] data,
  output logic          zero_o
);
  localparam int CW = $clog2(ZRUN + 1);
  localparam logic [CW-1:0] CMAX = CW'(ZRUN);

  logic [CW-1:0] cnt_q;
  logic          is_zero;
  logic          at_max;

  assign is_zero = (data == '0);
  assign at_max  = (cnt_q == CMAX);
  assign zero_o  = at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (vld) begin
      if (!is_zero)    cnt_q <= '0;
      else if (!at_max) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: a strobed nonzero sample ends the silent state
  p_nonzero_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !clr && data != '0) |=> !zero_o);

  // R4: silence only begins on a strobed zero sample
  p_rise_on_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_o) |-> $past(vld && data == '0));

  // R3: internal reset clears the run
  p_irst_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !zero_o);

endmodule

// File: rtl/zrun_grp_map.sv
module zrun_grp_map
  import zrun_pkg::*;
#(
  parameter int NCH = 12
) (
  input  logic [3:0]     mode,
  output logic [NCH-1:0] g_a,
  output logic [NCH-1:0] g_b
);

  // returns {in_b, in_a} for channel c under grouping code m
  function automatic logic [1:0] member(input logic [3:0] m, input int c);
    logic [1:0] r;
    case (m)
      ZR_MODE_ALL:  r = 2'b01;
      ZR_MODE_EVEN: r = (c % 2 == 0) ? 2'b01 : 2'b10;
      ZR_MODE_PAIR: r = ((c / 2) % 2 == 0) ? 2'b01 : 2'b10;
      ZR_MODE_BOTH: r = 2'b11;
      ZR_MODE_OFF:  r = 2'b00;
      default:      r = (c >= NCH - int'(m)) ? 2'b10 : 2'b01;
    endcase
    return r;
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign {g_b[c], g_a[c]} = member(mode, c);
  end

endmodule

// File: rtl/zrun_hold.sv
module zrun_hold #(
  parameter int HOLD_SMP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  output logic blank_o
);
  localparam int HW = $clog2(HOLD_SMP + 1);
  localparam logic [HW-1:0] HMAX = HW'(HOLD_SMP);

  logic [HW-1:0] hcnt_q;

  assign blank_o = (hcnt_q != HMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hcnt_q <= '0;
    else if (vld && blank_o) hcnt_q <= hcnt_q + 1'b1;
  end

  // R2: the window closes only on a counted strobe
  p_window_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_o) |-> $past(vld));

  // R2: once closed, the window stays closed until reset
  p_window_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_o |=> !blank_o);

endmodule

// File: rtl/zrun_flag_comb.sv
module zrun_flag_comb
  import zrun_pkg::*;
#(
  parameter int NCH = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           blank,
  input  logic           run_en,
  input  logic           ovf_sel,
  input  logic           ovf_in,
  input  logic           mode_off,
  input  logic [NCH-1:0] zero_vec,
  input  logic [NCH-1:0] pd,
  input  logic [NCH-1:0] g_a,
  input  logic [NCH-1:0] g_b,
  output logic           flag_a,
  output logic           flag_b
);

  zr_src_e        src;
  logic [NCH-1:0] live_a, live_b;
  logic           hit_a, hit_b;
  logic           nxt_a, nxt_b;

  // a group hits when it has a live member and no live member is busy
  function automatic logic group_hit(input logic [NCH-1:0] live,
                                     input logic [NCH-1:0] zv);
    return (live != '0) && ((live & ~zv) == '0);
  endfunction

  assign live_a = g_a & ~pd;
  assign live_b = g_b & ~pd;
  assign hit_a  = group_hit(live_a, zero_vec);
  assign hit_b  = group_hit(live_b, zero_vec);

  always_comb begin
    if (blank)        src = SRC_BLANK;
    else if (!run_en) src = SRC_IRST;
    else if (ovf_sel) src = SRC_OVF;
    else if (mode_off) src = SRC_OFF;
    else              src = SRC_GRP;
  end

  always_comb begin
    case (src)
      SRC_IRST: begin nxt_a = 1'b1;   nxt_b = 1'b1;  end
      SRC_OVF:  begin nxt_a = ovf_in; nxt_b = 1'b0;  end
      SRC_GRP:  begin nxt_a = hit_a;  nxt_b = hit_b; end
      default:  begin nxt_a = 1'b0;   nxt_b = 1'b0;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      flag_a <= nxt_a;
      flag_b <= nxt_b;
    end
  end

  p_blank_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (!flag_a && !flag_b));

  p_irst_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && !run_en) |=> (flag_a && flag_b));

  p_ovf_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && run_en && ovf_sel) |=> (flag_a == $past(ovf_in) && !flag_b));

  p_code_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && run_en && !ovf_sel && mode_off) |=> (!flag_a && !flag_b));

  p_empty_group_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && run_en && !ovf_sel && (g_a & ~pd) == '0) |=> !flag_a);

endmodule

// File: rtl/zrun_flag_top.sv
module zrun_flag_top
  import zrun_pkg::*;
#(
  parameter int NCH      = 12,
  parameter int DW       = 24,
  parameter int ZRUN     = 8192,
  parameter int HOLD_SMP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [3:0]        mode,
  input  logic              ovf_sel,
  input  logic              ovf_in,
  input  logic              sample_vld,
  input  logic [NCH-1:0]    ch_pd,
  input  logic [NCH*DW-1:0] ch_data,
  output logic              flag_a,
  output logic              flag_b
);

  logic [NCH-1:0] zero_vec;
  logic [NCH-1:0] g_a, g_b;
  logic           blank;
  logic           mode_off;

  assign mode_off = (mode == ZR_MODE_OFF);

  for (genvar c = 0; c < NCH; c++) begin : g_run
    zrun_chan #(.DW(DW), .ZRUN(ZRUN)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!run_en),
      .vld    (sample_vld),
      .data   (ch_data[c*DW +: DW]),
      .zero_o (zero_vec[c])
    );
  end

  zrun_grp_map #(.NCH(NCH)) u_map (
    .mode (mode),
    .g_a  (g_a),
    .g_b  (g_b)
  );

  zrun_hold #(.HOLD_SMP(HOLD_SMP)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (sample_vld),
    .blank_o (blank)
  );

  zrun_flag_comb #(.NCH(NCH)) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .blank    (blank),
    .run_en   (run_en),
    .ovf_sel  (ovf_sel),
    .ovf_in   (ovf_in),
    .mode_off (mode_off),
    .zero_vec (zero_vec),
    .pd       (ch_pd),
    .g_a      (g_a),
    .g_b      (g_b),
    .flag_a   (flag_a),
    .flag_b   (flag_b)
  );

endmodule

// File: tb/zrun_flag_top_tb.sv
`timescale 1ns/1ps
module zrun_flag_top_tb;
  localparam int NCH  = 12;
  localparam int DW   = 24;
  localparam int ZRUN = 16;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rst_n, run_en, ovf_sel, ovf_in, sample_vld;
  logic [3:0] mode;
  logic [NCH-1:0] ch_pd;
  logic [NCH*DW-1:0] ch_data;
  logic flag_a, flag_b;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  zrun_flag_top #(.NCH(NCH), .DW(DW), .ZRUN(ZRUN), .HOLD_SMP(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode(mode),
    .ovf_sel(ovf_sel), .ovf_in(ovf_in), .sample_vld(sample_vld),
    .ch_pd(ch_pd), .ch_data(ch_data), .flag_a(flag_a), .flag_b(flag_b)
  );

  // group membership written as a table lookup per code
  function automatic bit in_a(input logic [3:0] m, input int c);
    if (m == 4'd15) return 0;
    if (m == 4'd14) return 1;
    if (m == 4'd13) return (c % 4) < 2;
    if (m == 4'd12) return (c % 2) == 0;
    if (m == 4'd0)  return 1;
    return c < NCH - int'(m);
  endfunction

  function automatic bit in_b(input logic [3:0] m, input int c);
    if (m == 4'd15 || m == 4'd0) return 0;
    if (m == 4'd14) return 1;
    if (m == 4'd13) return (c % 4) >= 2;
    if (m == 4'd12) return (c % 2) == 1;
    return c >= NCH - int'(m);
  endfunction

  // bench model
  int    mcnt [NCH];
  int    mhold;
  logic  ea, eb;
  string etag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) mcnt[c] = 0;
      mhold = 0; ea = 0; eb = 0; etag = "R1";
    end else begin
      bit any_a, all_a, any_b, all_b;
      any_a = 0; all_a = 1; any_b = 0; all_b = 1;
      for (int c = 0; c < NCH; c++) begin
        if (!ch_pd[c] && in_a(mode, c)) begin any_a = 1; if (mcnt[c] != ZRUN) all_a = 0; end
        if (!ch_pd[c] && in_b(mode, c)) begin any_b = 1; if (mcnt[c] != ZRUN) all_b = 0; end
      end
      if (mhold < HOLD)      begin ea = 0; eb = 0; etag = "R2"; end
      else if (!run_en)      begin ea = 1; eb = 1; etag = "R3"; end
      else if (ovf_sel)      begin ea = ovf_in; eb = 0; etag = "R5"; end
      else if (mode == 4'd15) begin ea = 0; eb = 0; etag = "R6"; end
      else begin
        ea = any_a && all_a; eb = any_b && all_b;
        if (ch_pd != '0)        etag = "R10";
        else if (mode == 4'd0)  etag = "R7";
        else if (mode >= 4'd12) etag = "R9";
        else                    etag = "R8";
      end
      for (int c = 0; c < NCH; c++) begin
        if (!run_en) mcnt[c] = 0;
        else if (sample_vld) begin
          if (ch_data[c*DW +: DW] != '0) mcnt[c] = 0;
          else if (mcnt[c] < ZRUN) mcnt[c] = mcnt[c] + 1;
        end
      end
      if (sample_vld && mhold < HOLD) mhold = mhold + 1;
    end
  end

  // cycle scoreboard
  always @(negedge clk) begin
    checks++;
    if (flag_a !== ea || flag_b !== eb) begin
      errors++;
      $display("FAIL %s scoreboard flags=%b%b expected=%b%b at %0t", etag, flag_a, flag_b, ea, eb, $time);
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic set_all(input logic [DW-1:0] v);
    for (int c = 0; c < NCH; c++) ch_data[c*DW +: DW] = v;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; run_en = 0; mode = 4'd0; ovf_sel = 0; ovf_in = 0;
    sample_vld = 0; ch_pd = '0; ch_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset flag_a", flag_a, 1'b0);
    chk("R1 reset flag_b", flag_b, 1'b0);

    // R2: blank window with run_en low, strobe every cycle
    rst_n = 1; sample_vld = 1;
    for (int i = 1; i <= HOLD + 1; i++) begin
      @(negedge clk);
      if (i <= HOLD) chk("R2 blank window", flag_a, 1'b0);
      else           chk("R3 irst after window", flag_b, 1'b1);
    end

    // R4 / R11 directed run on mode 0
    run_en = 1; set_all('0);
    repeat (ZRUN - 1) @(negedge clk);
    sample_vld = 0; ch_data[3*DW +: DW] = 24'h000100;
    repeat (5) begin
      @(negedge clk);
      chk("R4 unstrobed nonzero ignored", flag_a, 1'b0);
    end
    sample_vld = 1; set_all('0);
    @(negedge clk); chk("R11 one cycle latency", flag_a, 1'b0);
    @(negedge clk); chk("R4 run complete", flag_a, 1'b1);
    chk("R7 group b empty", flag_b, 1'b0);
    ch_data[3*DW +: DW] = 24'h800000;
    @(negedge clk); chk("R11 old state still shown", flag_a, 1'b1);
    set_all('0);
    @(negedge clk); chk("R4 nonzero clears run", flag_a, 1'b0);

    // R10 directed: mask the busy channel, then all channels
    sample_vld = 0; ch_pd = 12'h008;
    @(negedge clk); chk("R10 busy channel masked", flag_a, 1'b1);
    ch_pd = '1;
    @(negedge clk); chk("R10 no live member", flag_a, 1'b0);
    ch_pd = '0;

    // R5 directed
    ovf_sel = 1; ovf_in = 1;
    @(negedge clk); chk("R5 overflow routed", flag_a, 1'b1);
    ovf_in = 0;
    @(negedge clk); chk("R5 overflow low", flag_a, 1'b0);
    chk("R5 flag_b low", flag_b, 1'b0);
    ovf_sel = 0;

    // random phases checked by the scoreboard
    for (int ph = 0; ph < 250; ph++) begin
      logic [NCH-1:0] quiet;
      mode    = 4'($urandom % 16);
      ch_pd   = ($urandom % 4 == 0) ? NCH'($urandom) : '0;
      ovf_sel = ($urandom % 10 == 0);
      run_en  = ($urandom % 12 != 0);
      quiet   = NCH'($urandom) | NCH'($urandom);
      if (ph == 120) begin
        rst_n = 0;
        @(negedge clk);
        chk("R1 mid-run reset flag_a", flag_a, 1'b0);
        chk("R1 mid-run reset flag_b", flag_b, 1'b0);
        rst_n = 1;
      end
      for (int cy = 0; cy < 64; cy++) begin
        sample_vld = ($urandom % 4 != 0);
        ovf_in = 1'($urandom);
        for (int c = 0; c < NCH; c++)
          ch_data[c*DW +: DW] = (!quiet[c] && $urandom % 8 == 0) ? (DW'($urandom) | 24'h1) : '0;
        @(negedge clk);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule